// File: doc/BRIEF.md
# Partial-Width Aliased General Register File

This block stores eight 32-bit general registers, with two read ports and one write port. Every access names a register number and a size. A narrow access covers only part of the register.

For every register, the 16-bit view covers bits 15:0. Registers 0 to 3 also have two byte views: the low byte covers bits 7:0 and the high byte covers bits 15:8. Registers 4 to 7 have no byte views, and a byte access to them is reported as illegal.

A narrow write merges its field into the stored 32-bit value in the same cycle. Bits outside the field are unchanged. A narrow read returns its field right-aligned and zero-extended. A read does not see a write made in the same cycle.

The size code is 2 bits:

| Code | Size |
|------|------|
| 0 | low byte |
| 1 | high byte |
| 2 | 16 bits |
| 3 | 32 bits |

Top module: `rf_alias_file`

## Requirements
- R1: While rst_ni is low, all eight registers are cleared to zero, and a read of any register at size code 3 returns 0.
- R2: A write at size code 3 replaces all 32 bits of the selected register, and a read at size code 3 returns all 32 bits.
- R3: A write at size code 2 to any register 0..7 stores wr_data_i[15:0] into bits 15:0 and leaves bits 31:16 unchanged.
- R4: A write at size code 0 to a register 0..3 stores wr_data_i[7:0] into bits 7:0 and leaves bits 31:8 unchanged.
- R5: A write at size code 1 to a register 0..3 stores wr_data_i[7:0] into bits 15:8 and leaves bits 31:16 and 7:0 unchanged.
- R6: A read at size code 0 returns bits 7:0 of the register in bits 7:0 of the output. A read at size code 1 returns bits 15:8 in bits 7:0. A read at size code 2 returns bits 15:0. In every case the unused upper output bits are zero.
- R7: A byte size (code 0 or 1) on a register 4..7 is illegal. On a read port it drives that port's error output high and its data to 0. On the write port it drives wr_err_o high and leaves every register unchanged.
- R8: A read in the same cycle as a write to the same register returns the value from before the write. The new value is visible from the next cycle.
- R9: An error output is low for every legal access, and wr_err_o is low whenever we_i is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Write enable |
| wr_sel_i | input | 3 | Write register number |
| wr_size_i | input | 2 | Write size code |
| wr_data_i | input | 32 | Write data, right-aligned field |
| wr_err_o | output | 1 | Illegal write access |
| ra_sel_i | input | 3 | Read port A register number |
| ra_size_i | input | 2 | Read port A size code |
| ra_data_o | output | 32 | Read port A data, zero-extended |
| ra_err_o | output | 1 | Read port A illegal access |
| rb_sel_i | input | 3 | Read port B register number |
| rb_size_i | input | 2 | Read port B size code |
| rb_data_o | output | 32 | Read port B data, zero-extended |
| rb_err_o | output | 1 | Read port B illegal access |

## Verification
A merge mask that is wrong corrupts bits outside the written field. Those bits are only seen when a later word-size read of the same register returns the wrong upper bits, so the bench reads whole words as well as fields after narrow writes.

A write that gets through when it should be suppressed changes the stored value. A later read shows this one cycle after the illegal write.

A wrong extraction shift, or a missing zero-extension, shows at once on the read data in the same cycle as the request.

// File: rtl/rf_alias_pkg.sv
package rf_alias_pkg;
  typedef enum logic [1:0] {
    SZ_LO8 = 2'd0,
    SZ_HI8 = 2'd1,
    SZ_H16 = 2'd2,
    SZ_W32 = 2'd3
  } acc_size_e;

  localparam int unsigned BYTE_W = 8;
  localparam int unsigned HALF_W = 16;
endpackage

// File: rtl/rf_slice_decode.sv
module rf_slice_decode
  import rf_alias_pkg::*;
#(
  parameter int unsigned NREG       = 8,
  parameter int unsigned XLEN       = 32,
  parameter int unsigned NBYTE_REGS = 4,
  localparam int unsigned SELW      = $clog2(NREG)
) (
  input  logic [SELW-1:0] sel_i,
  input  logic [1:0]      size_i,
  output logic            err_o,
  output logic            hi_o,
  output logic [XLEN-1:0] field_mask_o
);
  acc_size_e size;
  logic      is_byte;

  assign size    = acc_size_e'(size_i);
  assign is_byte = (size == SZ_LO8) || (size == SZ_HI8);
  assign err_o   = is_byte && (32'(sel_i) >= NBYTE_REGS);
  assign hi_o    = (size == SZ_HI8);

  always_comb begin
    unique case (size)
      SZ_LO8, SZ_HI8: field_mask_o = XLEN'({BYTE_W{1'b1}});
      SZ_H16:         field_mask_o = XLEN'({HALF_W{1'b1}});
      default:        field_mask_o = '1;
    endcase
  end
endmodule

// File: rtl/rf_read_port.sv
module rf_read_port
  import rf_alias_pkg::*;
#(
  parameter int unsigned NREG       = 8,
  parameter int unsigned XLEN       = 32,
  parameter int unsigned NBYTE_REGS = 4,
  localparam int unsigned SELW      = $clog2(NREG)
) (
  input  logic [NREG-1:0][XLEN-1:0] regs_i,
  input  logic [SELW-1:0]           sel_i,
  input  logic [1:0]                size_i,
  output logic [XLEN-1:0]           data_o,
  output logic                      err_o
);
  logic            hi;
  logic [XLEN-1:0] fmask;
  logic [XLEN-1:0] raw;

  rf_slice_decode #(.NREG(NREG), .XLEN(XLEN), .NBYTE_REGS(NBYTE_REGS)) i_dec (
    .sel_i        (sel_i),
    .size_i       (size_i),
    .err_o        (err_o),
    .hi_o         (hi),
    .field_mask_o (fmask)
  );

  assign raw    = hi ? (regs_i[sel_i] >> BYTE_W) : regs_i[sel_i];
  assign data_o = err_o ? '0 : (raw & fmask);
endmodule

// File: rtl/rf_write_merge.sv
module rf_write_merge
  import rf_alias_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [XLEN-1:0] old_i,
  input  logic [XLEN-1:0] wdata_i,
  input  logic [XLEN-1:0] field_mask_i,
  input  logic            hi_i,
  output logic [XLEN-1:0] new_o
);
  logic [XLEN-1:0] pos_mask;
  logic [XLEN-1:0] pos_data;

  assign pos_mask = hi_i ? (field_mask_i << BYTE_W) : field_mask_i;
  assign pos_data = hi_i ? ((wdata_i & field_mask_i) << BYTE_W) : (wdata_i & field_mask_i);
  assign new_o    = (old_i & ~pos_mask) | pos_data;
endmodule

// File: rtl/rf_alias_file.sv
module rf_alias_file
  import rf_alias_pkg::*;
#(
  parameter int unsigned NREG       = 8,
  parameter int unsigned XLEN       = 32,
  parameter int unsigned NBYTE_REGS = 4,
  localparam int unsigned SELW      = $clog2(NREG)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [SELW-1:0] wr_sel_i,
  input  logic [1:0]      wr_size_i,
  input  logic [XLEN-1:0] wr_data_i,
  output logic            wr_err_o,
  input  logic [SELW-1:0] ra_sel_i,
  input  logic [1:0]      ra_size_i,
  output logic [XLEN-1:0] ra_data_o,
  output logic            ra_err_o,
  input  logic [SELW-1:0] rb_sel_i,
  input  logic [1:0]      rb_size_i,
  output logic [XLEN-1:0] rb_data_o,
  output logic            rb_err_o
);
  logic [NREG-1:0][XLEN-1:0] regs_q;
  logic                      wr_bad;
  logic                      wr_hi;
  logic [XLEN-1:0]           wr_fmask;
  logic [XLEN-1:0]           wr_merged;

  rf_slice_decode #(.NREG(NREG), .XLEN(XLEN), .NBYTE_REGS(NBYTE_REGS)) i_wr_dec (
    .sel_i        (wr_sel_i),
    .size_i       (wr_size_i),
    .err_o        (wr_bad),
    .hi_o         (wr_hi),
    .field_mask_o (wr_fmask)
  );

  rf_write_merge #(.XLEN(XLEN)) i_merge (
    .old_i        (regs_q[wr_sel_i]),
    .wdata_i      (wr_data_i),
    .field_mask_i (wr_fmask),
    .hi_i         (wr_hi),
    .new_o        (wr_merged)
  );

  assign wr_err_o = we_i && wr_bad;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        regs_q[g] <= '0;
      end else if (we_i && !wr_bad && (32'(wr_sel_i) == g)) begin
        regs_q[g] <= wr_merged;
      end
    end
  end

  rf_read_port #(.NREG(NREG), .XLEN(XLEN), .NBYTE_REGS(NBYTE_REGS)) i_rd_a (
    .regs_i (regs_q),
    .sel_i  (ra_sel_i),
    .size_i (ra_size_i),
    .data_o (ra_data_o),
    .err_o  (ra_err_o)
  );

  rf_read_port #(.NREG(NREG), .XLEN(XLEN), .NBYTE_REGS(NBYTE_REGS)) i_rd_b (
    .regs_i (regs_q),
    .sel_i  (rb_sel_i),
    .size_i (rb_size_i),
    .data_o (rb_data_o),
    .err_o  (rb_err_o)
  );
endmodule

// File: rtl/rf_alias_file_chk.sv
module rf_alias_file_chk #(
  parameter int unsigned NREG = 8,
  parameter int unsigned XLEN = 32,
  localparam int unsigned SELW = $clog2(NREG)
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      we_i,
  input logic [SELW-1:0]           wr_sel_i,
  input logic [1:0]                wr_size_i,
  input logic                      wr_err_o,
  input logic [1:0]                ra_size_i,
  input logic [XLEN-1:0]           ra_data_o,
  input logic                      ra_err_o,
  input logic [1:0]                rb_size_i,
  input logic [XLEN-1:0]           rb_data_o,
  input logic [NREG-1:0][XLEN-1:0] regs_q
);
  logic [XLEN-1:0] tgt_q;

  assign tgt_q = regs_q[wr_sel_i];

  // R7
  suppressed_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_err_o |=> regs_q == $past(regs_q));

  // R3
  half_keeps_upper_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && wr_size_i == 2'd2) |=> regs_q[$past(wr_sel_i)][XLEN-1:16] == $past(tgt_q[XLEN-1:16]));

  // R5
  hi_byte_keeps_rest_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !wr_err_o && wr_size_i == 2'd1) |=>
      (regs_q[$past(wr_sel_i)][7:0] == $past(tgt_q[7:0])) &&
      (regs_q[$past(wr_sel_i)][XLEN-1:16] == $past(tgt_q[XLEN-1:16])));

  // R6
  ra_zero_ext_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ra_size_i != 2'd3) |-> ra_data_o[XLEN-1:16] == '0);

  // R6
  rb_byte_zero_ext_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rb_size_i[1] == 1'b0) |-> rb_data_o[XLEN-1:8] == '0);

  // R9
  no_wr_err_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |-> !wr_err_o);

  // R7
  ra_err_data_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ra_err_o |-> ra_data_o == '0);
endmodule

bind rf_alias_file rf_alias_file_chk #(.NREG(NREG), .XLEN(XLEN)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .we_i      (we_i),
  .wr_sel_i  (wr_sel_i),
  .wr_size_i (wr_size_i),
  .wr_err_o  (wr_err_o),
  .ra_size_i (ra_size_i),
  .ra_data_o (ra_data_o),
  .ra_err_o  (ra_err_o),
  .rb_size_i (rb_size_i),
  .rb_data_o (rb_data_o),
  .regs_q    (regs_q)
);

// File: tb/test_rf_alias_file.sv
module test_rf_alias_file;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        we_i = 1'b0;
  logic [2:0]  wr_sel_i = '0;
  logic [1:0]  wr_size_i = '0;
  logic [31:0] wr_data_i = '0;
  logic        wr_err_o;
  logic [2:0]  ra_sel_i = '0;
  logic [1:0]  ra_size_i = 2'd3;
  logic [31:0] ra_data_o;
  logic        ra_err_o;
  logic [2:0]  rb_sel_i = '0;
  logic [1:0]  rb_size_i = 2'd3;
  logic [31:0] rb_data_o;
  logic        rb_err_o;

  int unsigned n_chk = 0;
  int unsigned n_bad = 0;
  logic [31:0] model [8];

  always #5 clk_i = ~clk_i;

  rf_alias_file i_rf_alias_file (.*);

  function automatic logic bad_acc(logic [2:0] sel, logic [1:0] sz);
    return (sz[1] == 1'b0) && sel[2];
  endfunction

  function automatic logic [31:0] ref_read(logic [2:0] sel, logic [1:0] sz);
    logic [31:0] v = model[sel];
    if (bad_acc(sel, sz)) return 32'h0;
    case (sz)
      2'd0:    return {24'h0, v[7:0]};
      2'd1:    return {24'h0, v[15:8]};
      2'd2:    return {16'h0, v[15:0]};
      default: return v;
    endcase
  endfunction

  function automatic logic [31:0] ref_merge(logic [31:0] o, logic [1:0] sz, logic [31:0] d);
    case (sz)
      2'd0:    return {o[31:8], d[7:0]};
      2'd1:    return {o[31:16], d[7:0], o[7:0]};
      2'd2:    return {o[31:16], d[15:0]};
      default: return d;
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Drive one cycle at negedge, check reads (pre-write state), then commit on posedge.
  task automatic cycle(string req, logic we, logic [2:0] ws, logic [1:0] wz, logic [31:0] wd,
                       logic [2:0] as, logic [1:0] az, logic [2:0] bs, logic [1:0] bz);
    @(negedge clk_i);
    we_i = we; wr_sel_i = ws; wr_size_i = wz; wr_data_i = wd;
    ra_sel_i = as; ra_size_i = az; rb_sel_i = bs; rb_size_i = bz;
    #1;
    chk({req, " rdA"}, ra_data_o, ref_read(as, az));
    chk({req, " rdB"}, rb_data_o, ref_read(bs, bz));
    chk({req, " errA"}, 32'(ra_err_o), 32'(bad_acc(as, az)));
    chk({req, " errB"}, 32'(rb_err_o), 32'(bad_acc(bs, bz)));
    chk({req, " wr_err"}, 32'(wr_err_o), 32'(we && bad_acc(ws, wz)));
    @(posedge clk_i);
    if (we && !bad_acc(ws, wz)) model[ws] = ref_merge(model[ws], wz, wd);
  endtask

  initial begin
    #2000000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 8; i++) model[i] = '0;
    repeat (3) @(posedge clk_i);
    rst_ni = 1'b1;
    // R1 reset state
    for (int i = 0; i < 8; i += 2) cycle("R1", 0, 0, 3, 0, 3'(i), 3, 3'(i + 1), 3);
    // R2 full word
    cycle("R2", 1, 0, 3, 32'hFFFF_FFFF, 0, 3, 1, 3);
    cycle("R2", 1, 6, 3, 32'hDEAD_BEEF, 0, 3, 6, 3);
    // R4 low byte
    cycle("R4", 1, 0, 0, 32'hAAAA_AA12, 0, 3, 0, 0);
    chk("R4 word", model[0], 32'hFFFF_FF12);
    // R5 high byte
    cycle("R5", 1, 0, 1, 32'h0000_0034, 0, 3, 0, 1);
    cycle("R5", 0, 0, 0, 0, 0, 3, 0, 1);
    chk("R5 readback", ra_data_o, 32'hFFFF_3412);
    // R3 half on pointer register
    cycle("R3", 1, 6, 2, 32'h5555_ABCD, 6, 3, 6, 2);
    cycle("R3", 0, 0, 0, 0, 6, 3, 6, 2);
    chk("R3 readback", ra_data_o, 32'hDEAD_ABCD);
    // R7 illegal byte write to reg 5 and reads of reg 7
    cycle("R7", 1, 5, 0, 32'h0000_00FF, 5, 3, 7, 1);
    cycle("R7", 1, 7, 1, 32'h0000_00FF, 7, 3, 4, 0);
    cycle("R7", 0, 0, 0, 0, 5, 3, 7, 3);
    chk("R7 reg5 untouched", ra_data_o, 32'h0);
    // R8 same-cycle read returns old value
    cycle("R8", 1, 2, 3, 32'h1234_5678, 2, 3, 2, 0);
    cycle("R8", 1, 2, 0, 32'h0000_0099, 2, 3, 2, 0);
    chk("R8 old", model[2], 32'h1234_5699);
    // R6 / R9 random mix
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] r = $urandom;
      cycle("R6/R9 rand", r[0], r[3:1], r[5:4], $urandom, r[8:6], r[10:9], r[13:11], r[15:14]);
    end
    // R2 final word sweep of all registers
    for (int i = 0; i < 8; i++) cycle("R2 sweep", 0, 0, 0, 0, 3'(i), 3, 3'(i), 2);
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule